// File: doc/BRIEF.md
# Infrared Carrier Generator with Burst Timer

This block drives the modulated carrier of an infrared remote-control transmitter on one push-pull output. A select code picks the carrier source. Six sources divide the input clock frequency by 1, 4, 8, 12, 64 or 96, and the last is a constant high level. The logic runs on a reference clock at twice the input frequency, so every divided source is a registered square wave with exactly 50% duty.

An 8-bit down counter with its own reload register shapes the bursts. The counter is advanced by a prescaled tick. Each time it underflows, it reloads and inverts a gate flag. The carrier appears on the pin only while the timer runs and the gate is set, so the timer switches the carrier on and off with no further software action.

Software reaches the block through a small write port, which sets the select code, the reload value, the count and the run bit. The count can be read back at any time. A new select code is adopted only at a carrier period boundary, so no truncated pulses appear when the code changes.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, carr_o is 0 and cnt_o is 0. Reset also stops the timer, clears the gate and selects code 6.
- R2: A write to address 2 loads wr_data_i into the count, and cnt_o shows it one cycle later. While the timer is stopped, the count holds.
- R3: While running (address 3, bit 0 = 1), the count decrements by one every TICK_DIV clock cycles. The first decrement comes TICK_DIV cycles after the run bit is registered.
- R4: A tick that finds the count at 0 reloads the count from the reload register (address 1) in that same cycle.
- R5: Every underflow inverts the gate. The gate starts cleared, so the first count period after a start produces no carrier.
- R6: Select codes 0..5 (address 0, bits 3:0) give a carrier of period 2N clock cycles for N = 1, 4, 8, 12, 64, 96. That period is high for N cycles and then low for N cycles. Each burst begins with a full high phase one cycle after the gate opens.
- R7: Select code 6 drives carr_o high for the whole burst, which lasts (reload+1)*TICK_DIV cycles.
- R8: Select codes 7..15 behave like code 6.
- R9: Clearing the run bit forces carr_o low within two cycles and freezes the count.
- R10: A select change during a burst takes effect only at the end of a low phase. The current period always completes, and each low phase equals the high phase before it.
- R11: While the gate is clear or the timer is stopped, carr_o is low.
- R12: Starting the timer without writing a select code yields a constant-high burst, because reset selects code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the input frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 select, 1 reload, 2 count, 3 control |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current timer count |
| carr_o | output | 1 | Gated carrier output |

## Verification
The hardest situation to reach is a select change in the middle of an active burst. It must land inside a running carrier period, and the result is visible only as the pattern of pulse widths that follows. The stimulus starts a long burst with divide-by-4, waits until the gate has opened, and writes divide-by-8 at an arbitrary cycle. It then records every output level for a window of several hundred cycles. The recorded waveform is cut into pulses, and each complete low phase is compared with the high phase before it, which exposes any runt pulse. The same window confirms that both widths occur in order.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
  localparam int SEL_W  = 4;
  localparam int HALF_W = 7;

  typedef enum logic [1:0] {
    A_SEL    = 2'd0,
    A_RELOAD = 2'd1,
    A_COUNT  = 2'd2,
    A_CTRL   = 2'd3
  } reg_addr_e;

  localparam logic [SEL_W-1:0] SEL_FIXED = 4'd6;

  // half period in reference cycles; 0 marks the fixed-high source
  function automatic logic [HALF_W-1:0] half_len(input logic [SEL_W-1:0] code);
    case (code)
      4'd0:    half_len = 7'd1;
      4'd1:    half_len = 7'd4;
      4'd2:    half_len = 7'd8;
      4'd3:    half_len = 7'd12;
      4'd4:    half_len = 7'd64;
      4'd5:    half_len = 7'd96;
      default: half_len = 7'd0;
    endcase
  endfunction

  function automatic logic is_fixed(input logic [SEL_W-1:0] code);
    is_fixed = (code > 4'd5);
  endfunction
endpackage

// File: rtl/ircg_regs.sv
module ircg_regs
  import ircg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             run_o,
  output logic             ld_o,
  output logic [CNT_W-1:0] ld_val_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= SEL_FIXED;
      reload_o <= '0;
      run_o    <= 1'b0;
    end else if (wr_en_i) begin
      case (addr)
        A_SEL:    sel_o    <= wr_data_i[SEL_W-1:0];
        A_RELOAD: reload_o <= wr_data_i;
        A_CTRL:   run_o    <= wr_data_i[0];
        default:  ;
      endcase
    end
  end

  assign ld_o     = wr_en_i && (addr == A_COUNT);
  assign ld_val_o = wr_data_i;
endmodule

// File: rtl/ircg_timer.sv
module ircg_timer #(
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             gate_o,
  output logic             tick_o,
  output logic             uf_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  generate
    if (TICK_DIV > 1) begin : g_pre
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              pre_q <= '0;
        else if (!run_i || tick_o) pre_q <= '0;
        else                      pre_q <= pre_q + 1'b1;
      end
      assign tick_o = run_i && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign pre_q  = '0;
      assign tick_o = run_i;
    end
  endgenerate

  assign uf_o = tick_o && (cnt_o == '0) && !ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      gate_o <= 1'b0;
    end else begin
      if (ld_i)        cnt_o <= ld_val_i;
      else if (uf_o)   cnt_o <= reload_i;
      else if (tick_o) cnt_o <= cnt_o - 1'b1;
      if (uf_o) gate_o <= ~gate_o;
    end
  end
endmodule

// File: rtl/ircg_wave.sv
module ircg_wave
  import ircg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             carr_o,
  output logic             act_fixed_o
);
  logic [SEL_W-1:0]  act_q, act_n;
  logic [HALF_W-1:0] ph_q, ph_n, half_q;
  logic              wave_q, wave_n, en_q, start;

  assign half_q      = half_len(act_q);
  assign act_fixed_o = is_fixed(act_q);
  assign start       = en_i && !en_q;

  // hand-over of the select code only at the end of a low phase
  always_comb begin
    act_n  = act_q;
    ph_n   = ph_q;
    wave_n = wave_q;
    if (start || act_fixed_o) begin
      act_n  = sel_i;
      ph_n   = '0;
      wave_n = 1'b1;
    end else if (ph_q == half_q - 1'b1) begin
      ph_n   = '0;
      wave_n = ~wave_q;
      if (!wave_q) act_n = sel_i;
    end else begin
      ph_n = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= SEL_FIXED;
      ph_q   <= '0;
      wave_q <= 1'b0;
      en_q   <= 1'b0;
      carr_o <= 1'b0;
    end else begin
      act_q  <= act_n;
      ph_q   <= ph_n;
      wave_q <= wave_n;
      en_q   <= en_i;
      carr_o <= en_i && (is_fixed(act_n) || wave_n);
    end
  end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ircg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             carr_o
);
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] reload_q, ld_val;
  logic             run_q, ld, gate_q, tick, uf, en, act_fixed;

  ircg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .sel_o    (sel_q),
    .reload_o (reload_q),
    .run_o    (run_q),
    .ld_o     (ld),
    .ld_val_o (ld_val)
  );

  ircg_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .ld_i    (ld),
    .ld_val_i(ld_val),
    .reload_i(reload_q),
    .cnt_o   (cnt_o),
    .gate_o  (gate_q),
    .tick_o  (tick),
    .uf_o    (uf)
  );

  assign en = run_q && gate_q;

  ircg_wave u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .sel_i      (sel_q),
    .carr_o     (carr_o),
    .act_fixed_o(act_fixed)
  );
endmodule

// File: rtl/ircg_checker.sv
module ircg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             gate_i,
  input logic             tick_i,
  input logic             uf_i,
  input logic             ld_i,
  input logic             act_fixed_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] reload_i,
  input logic             carr_i
);
  p_low_when_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && gate_i) |=> !carr_i);

  p_stop_freezes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_i) |=> $stable(cnt_i));

  p_reload_on_uf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == '0 && !ld_i) |=> (cnt_i == $past(reload_i)));

  p_decrement_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != '0 && !ld_i) |=> (cnt_i == $past(cnt_i) - 1'b1));

  p_gate_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> (gate_i != $past(gate_i)));

  p_gate_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uf_i |=> $stable(gate_i));

  p_fixed_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && gate_i && act_fixed_i) |=> carr_i);
endmodule

bind ir_carrier_gen ircg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_q),
  .gate_i     (gate_q),
  .tick_i     (tick),
  .uf_i       (uf),
  .ld_i       (ld),
  .act_fixed_i(act_fixed),
  .cnt_i      (cnt_o),
  .reload_i   (reload_q),
  .carr_i     (carr_o)
);

// File: tb/ir_carrier_gen_bench.sv
module ir_carrier_gen_bench;
  localparam int CNT_W    = 8;
  localparam int TICK_DIV = 4;
  localparam int GAP      = 100;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_addr_i = '0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic             carr_o;

  always #5 clk_i = ~clk_i;

  ir_carrier_gen #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_ir_carrier_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cnt_o    (cnt_o),
    .carr_o   (carr_o)
  );

  typedef struct {
    int    hi;
    int    lo;
    bit    use_lo;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_addr_i = a;
    wr_data_i = CNT_W'(d);
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // monitor: measures the first pulse of each burst and pops the expectation
  initial begin
    int   lowc;
    int   hi;
    int   lo;
    exp_t e;
    lowc = 0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) lowc = 0;
      else if (!carr_o) lowc++;
      else if (lowc > GAP && q.size() > 0) begin
        e  = q.pop_front();
        hi = 0;
        do begin
          hi++;
          @(negedge clk_i);
        end while (carr_o);
        lo = 1;
        while (lo <= GAP) begin
          @(negedge clk_i);
          if (carr_o) break;
          lo++;
        end
        chk(hi == e.hi, {e.req, " high width"}, hi, e.hi);
        if (e.use_lo) chk(lo == e.lo, {e.req, " low width"}, lo, e.lo);
        lowc = carr_o ? 0 : lo;
      end else lowc = 0;
    end
  end

  task automatic mode_case(input int code, input int hi, input int lo, input bit use_lo,
                           input string req);
    exp_t e;
    wr(2'd3, 0);
    repeat (5) @(negedge clk_i);
    wr(2'd0, code);
    wr(2'd1, 63);
    wr(2'd2, 63);
    e.hi = hi; e.lo = lo; e.use_lo = use_lo; e.req = req;
    q.push_back(e);
    wr(2'd3, 1);
    repeat (700) @(negedge clk_i);
    wr(2'd3, 0);
    repeat (10) @(negedge clk_i);
    chk(q.size() == 0, {req, " burst observed"}, q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    bit lv[300];
    int seg_len[$];
    bit seg_val[$];
    int hold;
    bit runt_ok;
    int bad_w;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(carr_o == 1'b0, "R1 carr_o after reset", carr_o, 0);
    chk(cnt_o == '0, "R1 cnt_o after reset", cnt_o, 0);

    // R2 load while stopped
    wr(2'd2, 8'h37);
    chk(cnt_o == 8'h37, "R2 count load", cnt_o, 8'h37);
    repeat (10) @(negedge clk_i);
    chk(cnt_o == 8'h37, "R2 count holds while stopped", cnt_o, 8'h37);

    // R3 / R4 / R5 / R12 with reset-default select
    wr(2'd1, 5);
    wr(2'd2, 3);
    wr(2'd3, 1);
    for (int k = 1; k <= 3; k++) begin
      repeat (TICK_DIV) @(negedge clk_i);
      chk(cnt_o == CNT_W'(3 - k), "R3 decrement", cnt_o, 3 - k);
      chk(carr_o == 1'b0, "R5 no carrier before first underflow", carr_o, 0);
    end
    repeat (TICK_DIV) @(negedge clk_i);
    chk(cnt_o == 8'd5, "R4 reload on underflow", cnt_o, 5);
    chk(carr_o == 1'b0, "R11 output low in underflow cycle", carr_o, 0);
    @(negedge clk_i);
    chk(carr_o == 1'b1, "R12 default select is fixed high", carr_o, 1);
    wr(2'd3, 0);
    do_reset();

    // R6 divided sources
    mode_case(0, 1, 1, 1'b1, "R6 div1");
    mode_case(1, 4, 4, 1'b1, "R6 div4");
    mode_case(2, 8, 8, 1'b1, "R6 div8");
    mode_case(3, 12, 12, 1'b1, "R6 div12");
    mode_case(4, 64, 64, 1'b1, "R6 div64");
    mode_case(5, 96, 96, 1'b1, "R6 div96");
    // R7 / R8 fixed high for a whole burst of 64*TICK_DIV cycles
    mode_case(6, 64 * TICK_DIV, 0, 1'b0, "R7 fixed high");
    mode_case(11, 64 * TICK_DIV, 0, 1'b0, "R8 code 11 fixed high");

    // R10 select change inside a burst
    wr(2'd0, 1);
    wr(2'd1, 255);
    wr(2'd2, 255);
    wr(2'd3, 1);
    repeat (1100) @(negedge clk_i);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      lv[i] = carr_o;
      if (i == 97) begin
        wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'd2;
      end else if (i == 98) wr_en_i = 1'b0;
    end
    hold = 1;
    for (int i = 1; i < 300; i++) begin
      if (lv[i] == lv[i-1]) hold++;
      else begin
        seg_len.push_back(hold);
        seg_val.push_back(lv[i-1]);
        hold = 1;
      end
    end
    runt_ok = 1'b1;
    bad_w = 0;
    for (int j = 1; j + 1 < seg_len.size(); j++) begin
      if (seg_len[j] != 4 && seg_len[j] != 8) begin runt_ok = 1'b0; bad_w = seg_len[j]; end
      if (seg_val[j] == 1'b1 && seg_len[j+1] != seg_len[j] && j + 2 < seg_len.size()) begin
        runt_ok = 1'b0; bad_w = seg_len[j+1];
      end
    end
    chk(runt_ok, "R10 no runt pulse on select change", bad_w, 4);
    chk(seg_len.size() > 4 && seg_len[1] == 4, "R10 old width before change",
        seg_len.size() > 1 ? seg_len[1] : 0, 4);
    chk(seg_len.size() > 4 && seg_len[seg_len.size()-2] == 8, "R10 new width after change",
        seg_len.size() > 2 ? seg_len[seg_len.size()-2] : 0, 8);

    // R9 stop mid-burst
    wr(2'd3, 0);
    @(negedge clk_i);
    chk(carr_o == 1'b0, "R9 output low after stop", carr_o, 0);
    hold = int'(cnt_o);
    repeat (20) @(negedge clk_i);
    chk(int'(cnt_o) == hold, "R9 count frozen after stop", cnt_o, hold);
    chk(carr_o == 1'b0, "R11 output stays low while stopped", carr_o, 0);

    done = 1'b1;
    finish_run();
  end
endmodule